// File: doc/BRIEF.md
# Seed-XOR Single-Input-Change Pattern Generator

This block generates low-switching test vectors for built-in self-test. It holds two registers of equal width. The first is a seed register, stepped by a maximal-length LFSR. The second is a reconfigurable shift register that runs either as a twisted-ring (Johnson) counter or as a plain rotator. Each output bit is the XOR of one bit from each register. The two registers have separate step enables, which a small controller issues. The controller spends one cycle stepping the seed and then sixteen cycles stepping the shift register. Within such a group, Johnson mode makes each vector differ from the one before it in exactly one bit position.

A start pulse loads the mode and the wanted number of vectors, then returns both registers to their start values. The block emits one vector per cycle while a group runs and stops once the programmed count has been emitted. When it stops, it raises a done flag and holds both registers. A behavioural model of the scan chains sits behind the generator. Each emitted vector shifts one bit into each of W chains of length CHAIN_LEN, and a flag reports when every cell has been written since the last start.

Top module: `msic_tpg`

## Requirements
- R1: While `vec_valid` is high, `vec` equals the bitwise XOR of the shift register and the seed register.
- R2: The seed register starts at 8'h01 after reset and after every start. Each step shifts it left and places the XOR of bits 7, 5, 4 and 3 into bit 0. It steps once before each group and at no other time.
- R3: The shift register starts at 8'h0F after reset and after every start. With `rot_mode` = 0 it shifts left and takes the inverted bit 7 into bit 0. With `rot_mode` = 1 it rotates left. `rot_mode` is sampled only in the start cycle.
- R4: Each group is one cycle with `vec_valid` low, in which the seed steps, followed by 2·W = 16 cycles with `vec_valid` high. The only exception is a group cut short by the end of the test.
- R5: With `rot_mode` = 0, two consecutive valid vectors in the same group differ in exactly one bit.
- R6: Exactly `test_len` vectors are emitted, counting from the last start. The cycle after the last vector, `done` rises, `vec_valid` stays low and `vec` holds its value. A `test_len` of 0 gives `done` with no vector.
- R7: If the last vector is also the last of its group, the controller does not step the seed. The held `vec` is then the last seed XOR the shift register stepped once more.
- R8: On each valid vector, chain i shifts `vec[i]` into its cell 0, and each older cell moves one place on. Cell k of chain i appears at `scan_cells[i*CHAIN_LEN+k]`. A start clears all cells.
- R9: `chains_loaded` rises once CHAIN_LEN = 4 vectors have been emitted since the last start, and stays high until the next start or reset.
- R10: A start in any state, including in the middle of a group, restarts the sequence from the start values of R2 and R3.
- R11: While reset is applied, and afterwards until the first start, the outputs are `vec_valid` = 0, `done` = 0, `vec` = 8'h0E, all scan cells 0 and `chains_loaded` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Pulse: initialise registers and begin a test |
| rot_mode | input | 1 | 0 Johnson stepping, 1 plain rotation; sampled with start |
| test_len | input | LEN_W | Number of vectors to emit; sampled with start |
| vec | output | W | Current pattern, shift register XOR seed |
| vec_valid | output | 1 | High in each cycle a pattern is emitted |
| done | output | 1 | Programmed count reached; registers frozen |
| scan_cells | output | W*CHAIN_LEN | Flattened contents of the scan-chain model |
| chains_loaded | output | 1 | Every scan cell written since the last start |

## Verification
Two events can fall in the same cycle: the end of the test length and the end of a seed group. In that cycle the controller must choose the stop over another seed step. The bench provokes this with a test length of exactly one group, 16 vectors. It judges the outcome from the held vector after `done`, which must still carry the last seed and not its successor. A second overlap, a start arriving in the middle of a group, is provoked by restarting a long run after a few vectors. The run that follows must match a fresh sequence from its first vector.

// File: rtl/msic_pkg.sv
package msic_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SEED = 2'd1,
    ST_RUN  = 2'd2,
    ST_FIN  = 2'd3
  } tpg_state_t;

endpackage

// File: rtl/msic_ctrl.sv
module msic_ctrl
  import msic_pkg::*;
#(
  parameter int LEN_W = 16,
  parameter int GROUP = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [LEN_W-1:0] test_len,
  input  logic             rot_mode,
  output logic             init_en,
  output logic             seed_en,
  output logic             shift_en,
  output logic             vec_valid,
  output logic             done,
  output logic             mode_q
);

  localparam int STEP_W = (GROUP > 2) ? $clog2(GROUP) : 1;
  localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(GROUP - 1);

  tpg_state_t       state_q, state_n;
  logic [STEP_W-1:0] step_q, step_n;
  logic [LEN_W-1:0]  cnt_q, cnt_n;
  logic [LEN_W-1:0]  len_q, len_n;
  logic              mode_n;
  logic              last_vec;

  assign last_vec = (cnt_q == (len_q - 1'b1));

  always_comb begin
    state_n = state_q;
    step_n  = step_q;
    cnt_n   = cnt_q;
    len_n   = len_q;
    mode_n  = mode_q;
    if (start) begin
      mode_n  = rot_mode;
      len_n   = test_len;
      cnt_n   = '0;
      step_n  = '0;
      state_n = (test_len == '0) ? ST_FIN : ST_SEED;
    end else begin
      unique case (state_q)
        ST_SEED: begin
          state_n = ST_RUN;
          step_n  = '0;
        end
        ST_RUN: begin
          cnt_n  = cnt_q + 1'b1;
          step_n = step_q + 1'b1;
          if (last_vec) begin
            state_n = ST_FIN;
          end else if (step_q == LAST_STEP) begin
            state_n = ST_SEED;
          end
        end
        default: state_n = state_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      step_q  <= '0;
      cnt_q   <= '0;
      len_q   <= '0;
      mode_q  <= 1'b0;
    end else begin
      state_q <= state_n;
      step_q  <= step_n;
      cnt_q   <= cnt_n;
      len_q   <= len_n;
      mode_q  <= mode_n;
    end
  end

  assign init_en   = start;
  assign seed_en   = (state_q == ST_SEED) && !start;
  assign shift_en  = (state_q == ST_RUN) && !start;
  assign vec_valid = (state_q == ST_RUN) && !start;
  assign done      = (state_q == ST_FIN);

endmodule

// File: rtl/msic_seed_lfsr.sv
module msic_seed_lfsr #(
  parameter int           W    = 8,
  parameter logic [W-1:0] INIT = 'h01,
  parameter logic [W-1:0] TAPS = 'hB8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         init_en,
  input  logic         step_en,
  output logic [W-1:0] seed
);

  logic [W-1:0] seed_n;
  logic         feedback;

  assign feedback = ^(seed & TAPS);

  always_comb begin
    seed_n = seed;
    if (init_en) begin
      seed_n = INIT;
    end else if (step_en) begin
      seed_n = {seed[W-2:0], feedback};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seed <= INIT;
    end else begin
      seed <= seed_n;
    end
  end

endmodule

// File: rtl/msic_shift_reg.sv
module msic_shift_reg #(
  parameter int           W    = 8,
  parameter logic [W-1:0] INIT = 'h0F
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         init_en,
  input  logic         step_en,
  input  logic         rotate,
  output logic [W-1:0] ring
);

  logic [W-1:0] ring_n;
  logic         wrap_bit;

  assign wrap_bit = rotate ? ring[W-1] : ~ring[W-1];

  always_comb begin
    ring_n = ring;
    if (init_en) begin
      ring_n = INIT;
    end else if (step_en) begin
      ring_n = {ring[W-2:0], wrap_bit};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ring <= INIT;
    end else begin
      ring <= ring_n;
    end
  end

endmodule

// File: rtl/msic_scan_model.sv
module msic_scan_model #(
  parameter int W   = 8,
  parameter int LEN = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             shift_en,
  input  logic [W-1:0]     din,
  output logic [W*LEN-1:0] cells,
  output logic             loaded
);

  localparam int CNT_W = $clog2(LEN + 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(LEN);

  logic [CNT_W-1:0] fill_q, fill_n;

  always_comb begin
    fill_n = fill_q;
    if (clear) begin
      fill_n = '0;
    end else if (shift_en && (fill_q != FULL)) begin
      fill_n = fill_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fill_q <= '0;
    end else begin
      fill_q <= fill_n;
    end
  end

  assign loaded = (fill_q == FULL);

  for (genvar ch = 0; ch < W; ch++) begin : g_chain
    logic [LEN-1:0] chain_q, chain_n;

    always_comb begin
      chain_n = chain_q;
      if (clear) begin
        chain_n = '0;
      end else if (shift_en) begin
        if (LEN > 1) begin
          chain_n = {chain_q[LEN-2:0], din[ch]};
        end else begin
          chain_n = din[ch +: 1];
        end
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        chain_q <= '0;
      end else begin
        chain_q <= chain_n;
      end
    end

    assign cells[ch*LEN +: LEN] = chain_q;
  end

endmodule

// File: rtl/msic_tpg.sv
module msic_tpg #(
  parameter int           W         = 8,
  parameter int           CHAIN_LEN = 4,
  parameter int           LEN_W     = 16,
  parameter logic [W-1:0] SEED_INIT = 'h01,
  parameter logic [W-1:0] SEED_TAPS = 'hB8,
  parameter logic [W-1:0] RING_INIT = 'h0F
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   start,
  input  logic                   rot_mode,
  input  logic [LEN_W-1:0]       test_len,
  output logic [W-1:0]           vec,
  output logic                   vec_valid,
  output logic                   done,
  output logic [W*CHAIN_LEN-1:0] scan_cells,
  output logic                   chains_loaded
);

  localparam int GROUP = 2 * W;

  logic         init_en;
  logic         seed_en;
  logic         shift_en;
  logic         mode_q;
  logic [W-1:0] seed;
  logic [W-1:0] ring;

  msic_ctrl #(
    .LEN_W (LEN_W),
    .GROUP (GROUP)
  ) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .test_len  (test_len),
    .rot_mode  (rot_mode),
    .init_en   (init_en),
    .seed_en   (seed_en),
    .shift_en  (shift_en),
    .vec_valid (vec_valid),
    .done      (done),
    .mode_q    (mode_q)
  );

  msic_seed_lfsr #(
    .W    (W),
    .INIT (SEED_INIT),
    .TAPS (SEED_TAPS)
  ) u_seed (
    .clk     (clk),
    .rst_n   (rst_n),
    .init_en (init_en),
    .step_en (seed_en),
    .seed    (seed)
  );

  msic_shift_reg #(
    .W    (W),
    .INIT (RING_INIT)
  ) u_ring (
    .clk     (clk),
    .rst_n   (rst_n),
    .init_en (init_en),
    .step_en (shift_en),
    .rotate  (mode_q),
    .ring    (ring)
  );

  assign vec = ring ^ seed;

  msic_scan_model #(
    .W   (W),
    .LEN (CHAIN_LEN)
  ) u_scan (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (init_en),
    .shift_en (vec_valid),
    .din      (vec),
    .cells    (scan_cells),
    .loaded   (chains_loaded)
  );

endmodule

// File: rtl/msic_tpg_chk.sv
module msic_tpg_chk #(
  parameter int W     = 8,
  parameter int GROUP = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         start,
  input logic [W-1:0] vec,
  input logic         vec_valid,
  input logic         done,
  input logic         chains_loaded,
  input logic         mode_q
);

  localparam int RUN_W = $clog2(GROUP + 1);

  logic [RUN_W-1:0] run_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_cnt <= '0;
    end else if (vec_valid) begin
      run_cnt <= run_cnt + 1'b1;
    end else begin
      run_cnt <= '0;
    end
  end

  // R6: no vector is emitted once the count is reached
  p_no_valid_when_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(vec_valid && done));

  // R6: the held pattern stays put while finished
  p_frozen_after_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> (done && $stable(vec)));

  // R5: Johnson stepping changes one bit between neighbours in a group
  p_single_change_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_valid && !mode_q && $past(vec_valid) && !$past(start))
      |-> ($countones(vec ^ $past(vec)) == 1));

  // R4: no run of valid vectors is longer than one group
  p_group_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid |-> (run_cnt < RUN_W'(GROUP)));

  // R9: the loaded flag only drops with a new start
  p_loaded_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (chains_loaded && !start) |=> chains_loaded);

endmodule

bind msic_tpg msic_tpg_chk #(
  .W     (W),
  .GROUP (GROUP)
) u_msic_tpg_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .start         (start),
  .vec           (vec),
  .vec_valid     (vec_valid),
  .done          (done),
  .chains_loaded (chains_loaded),
  .mode_q        (mode_q)
);

// File: tb/test_msic_tpg.sv
`timescale 1ns/1ps
module test_msic_tpg;

  localparam int W = 8;
  localparam int L = 4;
  localparam int GRP = 2 * W;

  // {rot_mode, test_len}
  localparam int NRUNS = 6;
  localparam logic [16:0] RUNS [0:NRUNS-1] = '{
    {1'b0, 16'd40},
    {1'b1, 16'd20},
    {1'b0, 16'd16},
    {1'b0, 16'd1},
    {1'b0, 16'd0},
    {1'b1, 16'd3}
  };

  logic            clk;
  logic            rst_n;
  logic            start;
  logic            rot_mode;
  logic [15:0]     test_len;
  logic [W-1:0]    vec;
  logic            vec_valid;
  logic            done;
  logic [W*L-1:0]  scan_cells;
  logic            chains_loaded;

  int total_checks;
  int failed_checks;

  msic_tpg i_msic_tpg (
    .clk           (clk),
    .rst_n         (rst_n),
    .start         (start),
    .rot_mode      (rot_mode),
    .test_len      (test_len),
    .vec           (vec),
    .vec_valid     (vec_valid),
    .done          (done),
    .scan_cells    (scan_cells),
    .chains_loaded (chains_loaded)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  function automatic logic [7:0] lfsr_step(input logic [7:0] s);
    return {s[6:0], s[7] ^ s[5] ^ s[4] ^ s[3]};
  endfunction

  function automatic logic [7:0] ring_step(input logic [7:0] r, input logic m);
    return m ? {r[6:0], r[7]} : {r[6:0], ~r[7]};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    total_checks++;
    if (!ok) begin
      failed_checks++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic chk_reset_state(input string tag);
    chk(vec_valid == 1'b0, {tag, " R11 vec_valid"}, 32'(vec_valid), 0);
    chk(done == 1'b0, {tag, " R11 done"}, 32'(done), 0);
    chk(vec == 8'h0E, {tag, " R11 vec"}, 32'(vec), 32'h0E);
    chk(scan_cells == '0, {tag, " R11 scan_cells"}, scan_cells, 0);
    chk(chains_loaded == 1'b0, {tag, " R11 chains_loaded"}, 32'(chains_loaded), 0);
  endtask

  task automatic run_case(input logic m, input int len);
    logic [7:0]   es, er, prev, last_s, last_r, frz;
    logic [7:0]   hist [0:L-1];
    logic [W*L-1:0] exp_cells;
    int emitted, in_grp, run_len, gap;
    bit fin;
    @(negedge clk);
    start = 1'b1; rot_mode = m; test_len = 16'(len);
    @(negedge clk);
    start = 1'b0; rot_mode = ~m;  // R3: ignored outside the start cycle
    es = lfsr_step(8'h01); er = 8'h0F; prev = '0;
    last_s = 8'h01; last_r = 8'h0F;
    for (int k = 0; k < L; k++) hist[k] = '0;
    emitted = 0; in_grp = 0; run_len = 0; gap = 0; fin = 1'b0;
    for (int cyc = 0; cyc < 400 && !fin; cyc++) begin
      if (vec_valid) begin
        if (run_len == 0) chk(gap == 1, "R4 seed-step gap", 32'(gap), 1);
        chk(vec == (es ^ er), "R1/R2/R3 vector", 32'(vec), 32'(es ^ er));
        if (!m && in_grp > 0)
          chk($countones(vec ^ prev) == 1, "R5 one-bit change",
              32'(vec ^ prev), 32'h1);
        prev = vec;
        for (int k = L - 1; k > 0; k--) hist[k] = hist[k-1];
        hist[0] = es ^ er;
        last_s = es; last_r = er;
        emitted++; run_len++; gap = 0;
        er = ring_step(er, m);
        in_grp++;
        if (in_grp == GRP) begin
          es = lfsr_step(es);
          in_grp = 0;
        end
      end else if (done) begin
        fin = 1'b1;
      end else begin
        if (run_len > 0) chk(run_len == GRP, "R4 group length", 32'(run_len), 32'(GRP));
        run_len = 0;
        gap++;
      end
      if (!fin) @(negedge clk);
    end
    chk(done == 1'b1, "R6 done raised", 32'(done), 1);
    chk(emitted == len, "R6 vector count", 32'(emitted), 32'(len));
    frz = (len == 0) ? 8'h0E : (last_s ^ ring_step(last_r, m));
    chk(vec == frz, (len == GRP) ? "R7 stop at group end" : "R6 held vector",
        32'(vec), 32'(frz));
    for (int ch = 0; ch < W; ch++)
      for (int k = 0; k < L; k++)
        exp_cells[ch*L + k] = hist[k][ch];
    chk(scan_cells == exp_cells, "R8 scan cells", scan_cells, exp_cells);
    chk(chains_loaded == (emitted >= L), "R9 chains_loaded",
        32'(chains_loaded), 32'(emitted >= L));
    repeat (3) @(negedge clk);
    chk(vec == frz && !vec_valid && done, "R6 frozen after done",
        {vec_valid, done, 22'd0, vec}, {1'b0, 1'b1, 22'd0, frz});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total_checks++;
    failed_checks++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("%0d/%0d checks passed", total_checks - failed_checks, total_checks);
    $finish;
  end

  initial begin
    total_checks = 0;
    failed_checks = 0;
    rst_n = 1'b0; start = 1'b0; rot_mode = 1'b0; test_len = '0;
    repeat (3) @(negedge clk);
    chk_reset_state("in reset");
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk_reset_state("idle");

    for (int i = 0; i < NRUNS; i++)
      run_case(RUNS[i][16], int'(RUNS[i][15:0]));

    // R10: restart in the middle of a group
    @(negedge clk);
    start = 1'b1; rot_mode = 1'b0; test_len = 16'd40;
    @(negedge clk);
    start = 1'b0;
    repeat (7) @(negedge clk);
    chk(vec_valid == 1'b1, "R10 mid-group before restart", 32'(vec_valid), 1);
    run_case(1'b1, 5);
    run_case(1'b0, 18);

    // R11: asynchronous reset during a run
    @(negedge clk);
    start = 1'b1; rot_mode = 1'b0; test_len = 16'd30;
    @(negedge clk);
    start = 1'b0;
    repeat (6) @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk_reset_state("mid-run reset");
    @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk_reset_state("after reset");

    $display("%0d/%0d checks passed", total_checks - failed_checks, total_checks);
    $finish;
  end

endmodule